// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address by reading a two-level page table from memory. A miss arrives as a virtual page number together with the current value of the root-pointer register. The root pointer is the physical page number of the first-level table. The walker splits the page number into a 10-bit first-level index and a 10-bit second-level index. It reads the first-level entry, then reads the second-level entry from the table that entry names, and returns the final physical page number as a refill for the translation buffer.

Every entry is one 32-bit word. Bit 0 marks the entry as present, and bits 31:12 hold a physical page number. If either entry is absent, the walk stops at once and a page fault is reported for the page that missed. The fault tells the handler which level was absent. Only one walk is in flight at a time. The memory port issues one read with a valid/ready handshake and accepts the reply on a response-valid strobe, which may arrive after any delay.

Top module: `pt_walker`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, refill_valid and fault_valid are all 0.
- R2: The first read of a walk goes to address root_ppn*4096 + miss_vpn[19:10]*4, using the root_ppn value sampled in the cycle the miss is accepted. Later changes to root_ppn do not affect the walk.
- R3: The second read is requested only after the first-level response has arrived. It goes to address entry1[31:12]*4096 + miss_vpn[9:0]*4. No request is raised while a read is outstanding.
- R4: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid and its address does not change.
- R5: When the second-level entry has bit 0 set, refill_valid is 1 for exactly the cycle after that response. In that cycle refill_ppn equals entry2[31:12], and refill_vpn equals the accepted miss page number.
- R6: When the first-level entry has bit 0 clear, fault_valid is 1 in the cycle after that response, with fault_level 0 and fault_vpn equal to the miss page number. No second read is made.
- R7: When the second-level entry has bit 0 clear, fault_valid is 1 in the cycle after that response, with fault_level 1, and no refill is issued.
- R8: miss_ready is 0 from the cycle after a miss is accepted through the cycle of the refill or fault pulse, and is 1 again in the following cycle. Misses offered while it is 0 are not taken.
- R9: A mem_rsp_valid pulse while no read is outstanding is ignored. It produces no refill, no fault and no request.
- R10: refill_valid and fault_valid are never 1 together, and each stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_vpn | input | 20 | Virtual page number of the miss |
| miss_ready | output | 1 | Walker idle; a miss is taken when both valid and ready |
| root_ppn | input | 20 | Physical page number of the first-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| refill_valid | output | 1 | One-cycle refill strobe |
| refill_vpn | output | 20 | Page number being refilled |
| refill_ppn | output | 20 | Resolved physical page number |
| fault_valid | output | 1 | One-cycle page fault strobe |
| fault_vpn | output | 20 | Page number that faulted |
| fault_level | output | 1 | 0: first-level entry absent, 1: second-level entry absent |

## Verification
A wrong captured index or a stale root register shows up on the very first request of a walk as a wrong mem_req_addr. A corrupt second-level table pointer shows up one read later. A state machine that mis-sequences shows up within one cycle of a handshake or response, in one of several ways: a request that drops or moves before ready, a second request while a read is outstanding, a refill or fault pulse that is early, late or doubled, or miss_ready reopening too soon. A response that is wrongly consumed in idle surfaces as a spurious refill or fault in the next cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_REQ1,
      WS_WAIT1,
      WS_REQ2,
      WS_WAIT2,
      WS_DONE,
      WS_FAULT
   } walk_state_e;

endpackage

// File: rtl/pt_walker_addr.sv
// Entry address generator: table base page plus scaled index.
module pt_walker_addr #(
   parameter int PA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_SHIFT = 2,
   localparam int PPN_W      = PA_W - OFF_W
) (
   input  logic [PPN_W-1:0] table_ppn,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  entry_addr
);

   localparam int PAD_W = PA_W - IDX_W - ENTRY_SHIFT;

   logic [PA_W-1:0] base;
   logic [PA_W-1:0] step;

   assign base = {table_ppn, {OFF_W{1'b0}}};

   generate
      if (ENTRY_SHIFT == 0) begin : g_byte_entry
         assign step = {{PAD_W{1'b0}}, idx};
      end else begin : g_wide_entry
         assign step = {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
      end
   endgenerate

   assign entry_addr = base + step;

endmodule

// File: rtl/pt_walker_pte.sv
// Entry decoder: presence flag and page-number field.
module pt_walker_pte #(
   parameter int PTE_W     = 32,
   parameter int PPN_W     = 20,
   parameter int PPN_LSB   = 12,
   parameter int VALID_BIT = 0
) (
   input  logic [PTE_W-1:0] pte,
   output logic             present,
   output logic [PPN_W-1:0] ppn
);

   logic unused_pte_bits;

   assign present         = pte[VALID_BIT];
   assign ppn             = pte[PPN_LSB +: PPN_W];
   assign unused_pte_bits = ^pte;

endmodule

// File: rtl/pt_walker_fsm.sv
// Walk sequencer: one outstanding read, two levels, fault on absence.
module pt_walker_fsm
   import pt_walker_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic miss_fire,
   input  logic req_ready,
   input  logic rsp_valid,
   input  logic present,
   output logic idle,
   output logic req_valid,
   output logic req_lvl,
   output logic cap_tbl,
   output logic cap_leaf,
   output logic refill_pulse,
   output logic fault_pulse,
   output logic fault_lvl
);

   walk_state_e state_q, state_d;
   logic        fault_lvl_q, fault_lvl_d;

   always_comb begin
      state_d     = state_q;
      fault_lvl_d = fault_lvl_q;
      case (state_q)
         WS_IDLE:  if (miss_fire) state_d = WS_REQ1;
         WS_REQ1:  if (req_ready) state_d = WS_WAIT1;
         WS_WAIT1: if (rsp_valid) begin
            if (present) begin
               state_d = WS_REQ2;
            end else begin
               state_d     = WS_FAULT;
               fault_lvl_d = 1'b0;
            end
         end
         WS_REQ2:  if (req_ready) state_d = WS_WAIT2;
         WS_WAIT2: if (rsp_valid) begin
            if (present) begin
               state_d = WS_DONE;
            end else begin
               state_d     = WS_FAULT;
               fault_lvl_d = 1'b1;
            end
         end
         WS_DONE:  state_d = WS_IDLE;
         WS_FAULT: state_d = WS_IDLE;
         default:  state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= WS_IDLE;
         fault_lvl_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         fault_lvl_q <= fault_lvl_d;
      end
   end

   assign idle         = (state_q == WS_IDLE);
   assign req_valid    = (state_q == WS_REQ1) || (state_q == WS_REQ2);
   assign req_lvl      = (state_q == WS_REQ2);
   assign cap_tbl      = (state_q == WS_WAIT1) && rsp_valid && present;
   assign cap_leaf     = (state_q == WS_WAIT2) && rsp_valid && present;
   assign refill_pulse = (state_q == WS_DONE);
   assign fault_pulse  = (state_q == WS_FAULT);
   assign fault_lvl    = fault_lvl_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int L1_W        = 10,
   parameter int L2_W        = 10,
   parameter int PTE_W       = 32,
   parameter int ENTRY_BYTES = 4,
   parameter int VALID_BIT   = 0,
   localparam int VPN_W      = L1_W + L2_W,
   localparam int PPN_W      = PA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [VPN_W-1:0] miss_vpn,
   output logic             miss_ready,
   input  logic [PPN_W-1:0] root_ppn,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             refill_valid,
   output logic [VPN_W-1:0] refill_vpn,
   output logic [PPN_W-1:0] refill_ppn,
   output logic             fault_valid,
   output logic [VPN_W-1:0] fault_vpn,
   output logic             fault_level
);

   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
   localparam int PPN_LSB     = PTE_W - PPN_W;

   generate
      if (VA_W != VPN_W + OFF_W) begin : g_bad_split
         $error("virtual address split does not add up");
      end
      if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
         $error("entry size must be a power of two");
      end
      if (PTE_W < PPN_W + 1 || VALID_BIT >= PPN_LSB) begin : g_bad_pte
         $error("entry word too narrow for page number and flag");
      end
   endgenerate

   logic             miss_fire;
   logic             req_lvl, cap_tbl, cap_leaf, pte_present;
   logic [PPN_W-1:0] pte_ppn;
   logic [VPN_W-1:0] vpn_q;
   logic [PPN_W-1:0] root_q, tbl_q, leaf_q;
   logic [PA_W-1:0]  addr_l1, addr_l2;

   assign miss_fire = miss_valid && miss_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q  <= '0;
         root_q <= '0;
         tbl_q  <= '0;
         leaf_q <= '0;
      end else begin
         if (miss_fire) begin
            vpn_q  <= miss_vpn;
            root_q <= root_ppn;
         end
         if (cap_tbl)  tbl_q  <= pte_ppn;
         if (cap_leaf) leaf_q <= pte_ppn;
      end
   end

   pt_walker_addr #(
      .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(L1_W), .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_addr_l1 (
      .table_ppn (root_q),
      .idx       (vpn_q[VPN_W-1:L2_W]),
      .entry_addr(addr_l1)
   );

   pt_walker_addr #(
      .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(L2_W), .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_addr_l2 (
      .table_ppn (tbl_q),
      .idx       (vpn_q[L2_W-1:0]),
      .entry_addr(addr_l2)
   );

   pt_walker_pte #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PPN_LSB), .VALID_BIT(VALID_BIT)
   ) u_pte (
      .pte    (mem_rsp_data),
      .present(pte_present),
      .ppn    (pte_ppn)
   );

   pt_walker_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_fire   (miss_fire),
      .req_ready   (mem_req_ready),
      .rsp_valid   (mem_rsp_valid),
      .present     (pte_present),
      .idle        (miss_ready),
      .req_valid   (mem_req_valid),
      .req_lvl     (req_lvl),
      .cap_tbl     (cap_tbl),
      .cap_leaf    (cap_leaf),
      .refill_pulse(refill_valid),
      .fault_pulse (fault_valid),
      .fault_lvl   (fault_level)
   );

   assign mem_req_addr = req_lvl ? addr_l2 : addr_l1;
   assign refill_vpn   = vpn_q;
   assign refill_ppn   = leaf_q;
   assign fault_vpn    = vpn_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            miss_valid,
   input logic            miss_ready,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            refill_valid,
   input logic            fault_valid
);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R3
   one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready);

   // R8
   busy_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !miss_ready);

   // R8
   reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid || fault_valid) |=> miss_ready);

   // R10
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(refill_valid && fault_valid));

   // R10
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid || fault_valid) |=> (!refill_valid && !fault_valid));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .miss_valid   (miss_valid),
   .miss_ready   (miss_ready),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .refill_valid (refill_valid),
   .fault_valid  (fault_valid)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [19:0] miss_vpn = '0;
   logic        miss_ready;
   logic [19:0] root_ppn = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        refill_valid;
   logic [19:0] refill_vpn;
   logic [19:0] refill_ppn;
   logic        fault_valid;
   logic [19:0] fault_vpn;
   logic        fault_level;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [31:0] mem [logic [31:0]];

   always #2 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_vpn(miss_vpn), .miss_ready(miss_ready),
      .root_ppn(root_ppn),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
      .fault_valid(fault_valid), .fault_vpn(fault_vpn), .fault_level(fault_level)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] l1_addr(logic [19:0] root, logic [19:0] vpn);
      return {root, 12'h000} + {20'h0, vpn[19:10], 2'b00};
   endfunction

   function automatic logic [31:0] l2_addr(logic [19:0] tbl, logic [19:0] vpn);
      return {tbl, 12'h000} + {20'h0, vpn[9:0], 2'b00};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // One read: hold ready low rl cycles, then respond after sl idle cycles.
   task automatic serve(logic [31:0] addr, int rl, int sl, string tag);
      for (int i = 0; i < rl; i++) begin
         check({tag, " req valid"}, {31'h0, mem_req_valid}, 32'h1);
         check({tag, " req addr"}, mem_req_addr, addr);
         check("R8 busy", {31'h0, miss_ready}, 32'h0);
         step();
      end
      check({tag, " req valid"}, {31'h0, mem_req_valid}, 32'h1);
      check({tag, " req addr"}, mem_req_addr, addr);
      mem_req_ready = 1'b1;
      step();
      mem_req_ready = 1'b0;
      for (int i = 0; i < sl; i++) begin
         check("R3 no req while outstanding", {31'h0, mem_req_valid}, 32'h0);
         check("R10 no early pulse", {30'h0, refill_valid, fault_valid}, 32'h0);
         check("R8 busy", {31'h0, miss_ready}, 32'h0);
         step();
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rd(addr);
      step();
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hDEAD_BEEF;
   endtask

   task automatic walk(logic [19:0] vpn, logic [19:0] root,
                       int rl1, int sl1, int rl2, int sl2, bit poke);
      logic [31:0] a1, e1, a2, e2;
      a1 = l1_addr(root, vpn);
      e1 = rd(a1);
      a2 = l2_addr(e1[31:12], vpn);
      e2 = rd(a2);
      check("R8 ready when idle", {31'h0, miss_ready}, 32'h1);
      miss_valid = 1'b1;
      miss_vpn   = vpn;
      root_ppn   = root;
      step();
      miss_valid = poke;
      miss_vpn   = ~vpn;
      root_ppn   = ~root;
      serve(a1, rl1, sl1, "R2");
      if (!e1[0]) begin
         miss_valid = 1'b0;
         check("R6 fault", {31'h0, fault_valid}, 32'h1);
         check("R6 level", {31'h0, fault_level}, 32'h0);
         check("R6 vpn", {12'h0, fault_vpn}, {12'h0, vpn});
         check("R6 no refill", {31'h0, refill_valid}, 32'h0);
         check("R6 no second read", {31'h0, mem_req_valid}, 32'h0);
         check("R8 busy at pulse", {31'h0, miss_ready}, 32'h0);
      end else begin
         serve(a2, rl2, sl2, "R3");
         miss_valid = 1'b0;
         if (e2[0]) begin
            check("R5 refill", {31'h0, refill_valid}, 32'h1);
            check("R5 ppn", {12'h0, refill_ppn}, {12'h0, e2[31:12]});
            check("R5 vpn", {12'h0, refill_vpn}, {12'h0, vpn});
            check("R10 no fault", {31'h0, fault_valid}, 32'h0);
         end else begin
            check("R7 fault", {31'h0, fault_valid}, 32'h1);
            check("R7 level", {31'h0, fault_level}, 32'h1);
            check("R7 vpn", {12'h0, fault_vpn}, {12'h0, vpn});
            check("R7 no refill", {31'h0, refill_valid}, 32'h0);
         end
         check("R8 busy at pulse", {31'h0, miss_ready}, 32'h0);
      end
      step();
      check("R10 pulse ends", {30'h0, refill_valid, fault_valid}, 32'h0);
      check("R8 reopen", {31'h0, miss_ready}, 32'h1);
      check("R3 no stray req", {31'h0, mem_req_valid}, 32'h0);
   endtask

   task automatic map(logic [19:0] root, logic [19:0] vpn, logic [19:0] tbl,
                      logic [31:0] leaf_word);
      mem[l1_addr(root, vpn)] = {tbl, 12'h001};
      mem[l2_addr(tbl, vpn)]  = leaf_word;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ready", {31'h0, miss_ready}, 32'h1);
      check("R1 req", {31'h0, mem_req_valid}, 32'h0);
      check("R1 pulses", {30'h0, refill_valid, fault_valid}, 32'h0);
      rst_n = 1'b1;
      step();
      check("R1 ready after release", {31'h0, miss_ready}, 32'h1);

      map(20'h00010, 20'h12345, 20'h00020, 32'hABCDE001);
      map(20'h00010, 20'h00000, 20'h00021, 32'h13579FFF);
      map(20'h00030, 20'hFFFFF, 20'hFFFFE, 32'h00001001);
      mem[l1_addr(20'h00010, 20'h40000)] = 32'h00022001;
      mem[l2_addr(20'h00022, 20'h40000)] = 32'hFFFFF000;
      mem[l1_addr(20'h00010, 20'h80000)] = 32'hFFFFFFFE;

      walk(20'h12345, 20'h00010, 0, 0, 0, 0, 0);   // R5 zero latency
      walk(20'h12345, 20'h00010, 3, 5, 2, 1, 1);   // R4 R8 stalls, busy poke
      walk(20'h00000, 20'h00010, 1, 0, 0, 4, 0);   // R5 index zero
      walk(20'hFFFFF, 20'h00030, 0, 2, 4, 0, 1);   // R2 R3 top indices
      walk(20'h80000, 20'h00010, 2, 3, 0, 0, 0);   // R6 flag clear, other bits set
      walk(20'h7F001, 20'h00010, 0, 0, 0, 0, 1);   // R6 absent entry
      walk(20'h40000, 20'h00010, 1, 1, 3, 2, 0);   // R7

      // R9 response with no read outstanding
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'h12345001;
      step();
      mem_rsp_valid = 1'b0;
      check("R9 no pulse", {30'h0, refill_valid, fault_valid}, 32'h0);
      check("R9 no req", {31'h0, mem_req_valid}, 32'h0);
      check("R9 still ready", {31'h0, miss_ready}, 32'h1);
      step();
      check("R9 quiet", {30'h0, refill_valid, fault_valid}, 32'h0);
      walk(20'h12345, 20'h00010, 1, 2, 1, 2, 0);   // R9 walk unaffected

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule